// File: doc/BRIEF.md
# HDLC Controller Status Register

This block collects what an HDLC receive path and transmit path report and presents it to a host as one 8-bit status word, plus an interrupt line. Four bits are events. The receive path raises a frame-start pulse when it sees an opening byte. It raises a frame-end pulse when a frame closes, either with a good CRC or with a fault such as a CRC error, an overrun or an abort. The transmit path raises a message-done pulse. A spare bit-oriented-code event is also captured. Each event bit latches its pulse and stays set until the host reads the status word.

The other four bits are live levels taken from two occupancy counters, one for the receive FIFO and one for the transmit FIFO, each 64 bytes deep by default. Each counter tracks FIFO write and read strobes. The FIFO storage itself, the framing, the CRC and the bit stuffing are outside this block. An interrupt is raised whenever any status bit is set and the matching bit of a host-written mask is also set.

Top module: `hdlc_status_reg`

## Requirements
- R1: After reset `stat_q` is 0x06 (only transmit-not-full and transmit-half-empty set), `irq` is 0 and the mask is 0.
- R2: The status bit positions are: bit 0 bit-oriented-code event, bit 1 transmit-not-full, bit 2 transmit-half-empty, bit 3 receive-frame-start, bit 4 receive-not-empty, bit 5 receive-half-full, bit 6 receive-frame-end, bit 7 transmit-message-done. An event pulse sets its bit in the cycle after the pulse, and the bit stays set while no read occurs.
- R3: Bit 6 sets on either `ev_rx_end_ok` or `ev_rx_end_fault`.
- R4: A cycle with `host_rd` high clears every event bit (0, 3, 6, 7) whose own pulse is low in that cycle.
- R5: An event pulse in the same cycle as `host_rd` leaves its bit set after that cycle.
- R6: Bit 4 is 1 exactly while receive occupancy is at least 1.
- R7: Bit 5 is 1 exactly while receive occupancy is above half the depth (33 or more of 64).
- R8: Bit 2 is 1 exactly while transmit occupancy is below half the depth (under 32 of 64). Bit 1 is 1 exactly while transmit occupancy is below the depth.
- R9: A write strobe raises occupancy by one and a read strobe lowers it by one. Both strobes in one cycle leave it unchanged. A lone write at full depth and a lone read at zero are ignored.
- R10: `host_rd` has no effect on bits 1, 2, 4 and 5.
- R11: `mask_we` loads `mask_wd` into the mask. `irq` is 1 exactly when some bit of `stat_q` AND the mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_wr | input | 1 | Byte written into receive FIFO |
| rx_rd | input | 1 | Byte read from receive FIFO |
| tx_wr | input | 1 | Byte written into transmit FIFO |
| tx_rd | input | 1 | Byte taken from transmit FIFO |
| ev_rx_start | input | 1 | Opening byte detected (pulse) |
| ev_rx_end_ok | input | 1 | Frame closed with good CRC (pulse) |
| ev_rx_end_fault | input | 1 | Frame closed with CRC error, overrun or abort (pulse) |
| ev_tx_end | input | 1 | Transmit message finished (pulse) |
| ev_boc | input | 1 | Bit-oriented-code event (pulse) |
| host_rd | input | 1 | Host reads the status word this cycle |
| mask_we | input | 1 | Write strobe for interrupt mask |
| mask_wd | input | 8 | Interrupt mask write data |
| stat_q | output | 8 | Status word |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses from synchronous logic. They also assume that FIFO strobes may arrive at any occupancy, including writes at full depth and reads at zero. The counters are relied on to absorb those cases rather than the inputs being clean. The stimulus drives every input on the falling edge and holds it for exactly one clock. It deliberately overfills and overdrains both counters, and it places event pulses in the same cycle as status reads, so the merge and saturation rules are exercised within what the assertions permit.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
   localparam int STAT_W    = 8;
   localparam int BIT_BOC   = 0;
   localparam int BIT_TX_NF = 1;
   localparam int BIT_TX_HE = 2;
   localparam int BIT_RX_PS = 3;
   localparam int BIT_RX_NE = 4;
   localparam int BIT_RX_HF = 5;
   localparam int BIT_RX_PE = 6;
   localparam int BIT_TX_ME = 7;
   localparam int NUM_EVT   = 4;

   // event index -> status bit position
   function automatic int evt_pos(input int idx);
      case (idx)
         0:       return BIT_BOC;
         1:       return BIT_RX_PS;
         2:       return BIT_RX_PE;
         default: return BIT_TX_ME;
      endcase
   endfunction
endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          rd,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   initial assert (DEPTH >= 2) else $error("occ_counter: DEPTH must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (wr && !rd && cnt != FULL)
         cnt <= cnt + 1'b1;
      else if (rd && !wr && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rd) |=> $stable(cnt)); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && wr && !rd) |=> (cnt == FULL)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && rd && !wr) |=> (cnt == '0)); // R9
endmodule

// File: rtl/level_decode.sv
module level_decode #(
   parameter int DEPTH = 64,
   parameter bit IS_RX = 1'b1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] cnt,
   output logic          lvl_hi,
   output logic          lvl_lo
);
   localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   initial assert (DEPTH % 2 == 0) else $error("level_decode: DEPTH must be even");

   generate
      if (IS_RX) begin : g_rx
         assign lvl_hi = (cnt > HALF);   // half full
         assign lvl_lo = (cnt != '0);    // not empty
      end else begin : g_tx
         assign lvl_hi = (cnt < HALF);   // half empty
         assign lvl_lo = (cnt < FULL);   // not full
      end
   endgenerate
endmodule

// File: rtl/sticky_event.sv
module sticky_event (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag <= 1'b0;
      else if (pulse) flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
   end

   AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> flag); // R5
   AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pulse) |=> !flag); // R4
   AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag); // R2
endmodule

// File: rtl/hdlc_status_reg.sv
module hdlc_status_reg
   import hdlc_stat_pkg::*;
#(
   parameter int RX_DEPTH = 64,
   parameter int TX_DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_wr,
   input  logic              rx_rd,
   input  logic              tx_wr,
   input  logic              tx_rd,
   input  logic              ev_rx_start,
   input  logic              ev_rx_end_ok,
   input  logic              ev_rx_end_fault,
   input  logic              ev_tx_end,
   input  logic              ev_boc,
   input  logic              host_rd,
   input  logic              mask_we,
   input  logic [STAT_W-1:0] mask_wd,
   output logic [STAT_W-1:0] stat_q,
   output logic              irq
);
   localparam int RCW = $clog2(RX_DEPTH + 1);
   localparam int TCW = $clog2(TX_DEPTH + 1);

   logic [RCW-1:0]     rx_cnt;
   logic [TCW-1:0]     tx_cnt;
   logic               rx_hf, rx_ne, tx_he, tx_nf;
   logic [NUM_EVT-1:0] evt_in, evt_q;
   logic [STAT_W-1:0]  mask_q;

   occ_counter #(.DEPTH(RX_DEPTH)) u_rx_cnt (
      .clk(clk), .rst_n(rst_n), .wr(rx_wr), .rd(rx_rd), .cnt(rx_cnt));
   occ_counter #(.DEPTH(TX_DEPTH)) u_tx_cnt (
      .clk(clk), .rst_n(rst_n), .wr(tx_wr), .rd(tx_rd), .cnt(tx_cnt));

   level_decode #(.DEPTH(RX_DEPTH), .IS_RX(1'b1)) u_rx_lvl (
      .cnt(rx_cnt), .lvl_hi(rx_hf), .lvl_lo(rx_ne));
   level_decode #(.DEPTH(TX_DEPTH), .IS_RX(1'b0)) u_tx_lvl (
      .cnt(tx_cnt), .lvl_hi(tx_he), .lvl_lo(tx_nf));

   // event order matches hdlc_stat_pkg::evt_pos
   assign evt_in = {ev_tx_end, ev_rx_end_ok | ev_rx_end_fault, ev_rx_start, ev_boc};

   generate
      for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
         sticky_event u_evt (
            .clk(clk), .rst_n(rst_n), .pulse(evt_in[gi]),
            .clr(host_rd), .flag(evt_q[gi]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wd;
   end

   always_comb begin
      stat_q            = '0;
      stat_q[BIT_TX_NF] = tx_nf;
      stat_q[BIT_TX_HE] = tx_he;
      stat_q[BIT_RX_NE] = rx_ne;
      stat_q[BIT_RX_HF] = rx_hf;
      for (int i = 0; i < NUM_EVT; i++)
         stat_q[evt_pos(i)] = evt_q[i];
   end

   assign irq = |(stat_q & mask_q);

   AST_RXEND_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_end_ok || ev_rx_end_fault) |=> stat_q[BIT_RX_PE]); // R3
   AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !rx_wr && !rx_rd && !tx_wr && !tx_rd) |=>
      $stable({stat_q[BIT_RX_HF], stat_q[BIT_RX_NE], stat_q[BIT_TX_HE], stat_q[BIT_TX_NF]})); // R10
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && mask_wd == '0) |=> !irq); // R11
endmodule

// File: tb/hdlc_status_reg_bench.sv
module hdlc_status_reg_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_wr = 0, rx_rd = 0, tx_wr = 0, tx_rd = 0;
   logic ev_rx_start = 0, ev_rx_end_ok = 0, ev_rx_end_fault = 0, ev_tx_end = 0, ev_boc = 0;
   logic host_rd = 0, mask_we = 0;
   logic [7:0] mask_wd = '0;
   logic [7:0] stat_q;
   logic irq;

   always #10 clk = ~clk;  // 50 MHz

   hdlc_status_reg u_hdlc_status_reg (
      .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_rd(tx_rd),
      .ev_rx_start(ev_rx_start), .ev_rx_end_ok(ev_rx_end_ok), .ev_rx_end_fault(ev_rx_end_fault),
      .ev_tx_end(ev_tx_end), .ev_boc(ev_boc), .host_rd(host_rd), .mask_we(mask_we),
      .mask_wd(mask_wd), .stat_q(stat_q), .irq(irq));

   typedef struct packed {
      logic rxw, rxr, txw, txr, es, eok, ef, et, eb, rd, mwe;
      logic [7:0] mwd;
   } stim_t;

   typedef struct {
      logic [7:0] st;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_fail = 0;

   // reference model state
   int m_rx = 0, m_tx = 0;
   logic m_boc = 0, m_ps = 0, m_pe = 0, m_me = 0;
   logic [7:0] m_mask = '0;

   function automatic logic [7:0] model_stat();
      logic [7:0] s;
      s[0] = m_boc;
      s[1] = (m_tx < 64);
      s[2] = (m_tx < 32);
      s[3] = m_ps;
      s[4] = (m_rx >= 1);
      s[5] = (m_rx > 32);
      s[6] = m_pe;
      s[7] = m_me;
      return s;
   endfunction

   function automatic logic evt_next(logic cur, logic p, logic rd);
      if (p) return 1'b1;
      if (rd) return 1'b0;
      return cur;
   endfunction

   task automatic drive(stim_t s, string tag);
      exp_t e;
      @(negedge clk);
      rx_wr = s.rxw; rx_rd = s.rxr; tx_wr = s.txw; tx_rd = s.txr;
      ev_rx_start = s.es; ev_rx_end_ok = s.eok; ev_rx_end_fault = s.ef;
      ev_tx_end = s.et; ev_boc = s.eb; host_rd = s.rd; mask_we = s.mwe; mask_wd = s.mwd;
      if (s.rxw && !s.rxr && m_rx < 64) m_rx++;
      else if (s.rxr && !s.rxw && m_rx > 0) m_rx--;
      if (s.txw && !s.txr && m_tx < 64) m_tx++;
      else if (s.txr && !s.txw && m_tx > 0) m_tx--;
      m_boc = evt_next(m_boc, s.eb, s.rd);
      m_ps  = evt_next(m_ps, s.es, s.rd);
      m_pe  = evt_next(m_pe, s.eok | s.ef, s.rd);
      m_me  = evt_next(m_me, s.et, s.rd);
      if (s.mwe) m_mask = s.mwd;
      e.st = model_stat();
      e.irq = |(e.st & m_mask);
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: samples 5 ns after each rising edge
   always @(posedge clk) begin
      #5;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (stat_q !== e.st || irq !== e.irq) begin
            n_fail++;
            $display("FAIL %s: stat=%02h irq=%b expected stat=%02h irq=%b",
                     e.tag, stat_q, irq, e.st, e.irq);
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      stim_t s;
      repeat (3) @(posedge clk);
      #5;
      n_chk++;  // R1 reset state
      if (stat_q !== 8'h06 || irq !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: stat=%02h irq=%b expected stat=06 irq=0", stat_q, irq);
      end
      @(negedge clk); rst_n = 1'b1;

      s = '0; drive(s, "R1 idle after reset");
      // R2: each event sets its own bit and holds
      s = '0; s.eb = 1; drive(s, "R2 boc bit0");
      s = '0; drive(s, "R2 boc holds");
      s = '0; s.es = 1; drive(s, "R2 start bit3");
      s = '0; s.et = 1; drive(s, "R2 tx done bit7");
      // R4: read clears all events
      s = '0; s.rd = 1; drive(s, "R4 read clears");
      // R3: both frame-end sources
      s = '0; s.eok = 1; drive(s, "R3 end ok");
      s = '0; s.rd = 1; drive(s, "R4 clear end");
      s = '0; s.ef = 1; drive(s, "R3 end fault");
      // R5: event collides with read
      s = '0; s.rd = 1; s.ef = 1; s.eb = 1; drive(s, "R5 pulse during read");
      s = '0; drive(s, "R5 still set");
      s = '0; s.rd = 1; s.et = 1; drive(s, "R5 read with tx done");
      s = '0; s.rd = 1; drive(s, "R4 final clear");
      // R6 R7: fill receive counter past half
      for (int i = 0; i < 34; i++) begin
         s = '0; s.rxw = 1; drive(s, "R6 R7 rx fill");
      end
      // R10: read leaves levels alone
      s = '0; s.rd = 1; drive(s, "R10 read keeps rx levels");
      // R9: simultaneous strobes
      s = '0; s.rxw = 1; s.rxr = 1; drive(s, "R9 rx both strobes");
      for (int i = 0; i < 36; i++) begin
         s = '0; s.rxr = 1; drive(s, "R6 R7 R9 rx drain past empty");
      end
      s = '0; s.rxw = 1; s.rxr = 1; drive(s, "R9 both at empty");
      // R8: transmit fill to full and beyond
      for (int i = 0; i < 66; i++) begin
         s = '0; s.txw = 1; drive(s, "R8 R9 tx fill");
      end
      s = '0; s.rd = 1; drive(s, "R10 read keeps tx levels");
      s = '0; s.txr = 1; drive(s, "R8 tx not full again");
      // R11: mask and interrupt
      s = '0; s.mwe = 1; s.mwd = 8'h01; drive(s, "R11 mask boc, no event");
      s = '0; s.eb = 1; drive(s, "R11 boc raises irq");
      s = '0; s.rd = 1; drive(s, "R11 read drops irq");
      s = '0; s.mwe = 1; s.mwd = 8'h02; drive(s, "R11 mask tx not-full");
      s = '0; s.txw = 1; drive(s, "R11 tx full drops irq");
      s = '0; s.mwe = 1; s.mwd = 8'h00; s.es = 1; drive(s, "R11 zero mask");
      s = '0; drive(s, "R1 idle end");

      wait (q.size() == 0);
      @(posedge clk); #6;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule